// File: doc/BRIEF.md
# Reloadable VCO Cycle Divider

The divider sits in the feedback path of a fractional-N synthesizer. It is clocked directly by the oscillator and divides by an integer modulus that a noise-shaping quantiser supplies. The modulus may change on every output period. Each period ends with a one-cycle terminal pulse, which is the feedback edge for the phase detector.

In the same cycle as the pulse, the divider raises a request strobe that tells the quantiser to advance. It also samples the quantiser's modulus together with its valid flag, and that modulus governs the following period. Because the reload happens in the terminal cycle, no oscillator cycle is lost between periods. Each period therefore lasts exactly the number of cycles given by the modulus in force for it.

Top module: `vco_divider`

## Requirements
- R1: While rst_ni is low, fb_pulse_o and ratio_req_o are 0. After rst_ni is released, the first fb_pulse_o is high after exactly 89 rising clock edges. That is a first period of 90 cycles when the release cycle is counted.
- R2: ratio_req_o is high in exactly the cycles in which fb_pulse_o is high. Each pulse lasts one clock cycle.
- R3: If ratio_valid_i is 1 in a pulse cycle and ratio_i holds a value N with 4 <= N <= 255 (unsigned, 8 bits), the next pulse comes exactly N clock cycles later.
- R4: If ratio_valid_i is 1 in a pulse cycle and ratio_i is 0, 1, 2 or 3, the next pulse comes exactly 4 cycles later.
- R5: If ratio_valid_i is 0 in a pulse cycle, the next period reuses the ratio of the period that just ended. Before any ratio has been accepted after reset, that ratio is 90.
- R6: ratio_i and ratio_valid_i have no effect in cycles where fb_pulse_o is low. The length of the current period depends only on what was sampled at its starting pulse.
- R7: The largest modulus, 255, gives a period of 255 cycles. Consecutive periods follow each other with no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 8 | Division ratio from the quantiser |
| ratio_valid_i | input | 1 | ratio_i holds a new ratio |
| fb_pulse_o | output | 1 | One-cycle terminal pulse, feedback edge to the phase detector |
| ratio_req_o | output | 1 | Strobe telling the quantiser to advance |

## Verification
The assertions are checked on every cycle:
- Every pulse interval matches the ratio accepted at the previous pulse, including clamping and reuse when no valid ratio is offered.
- No interval exceeds that ratio.
- Two pulses are never closer together than the minimum ratio.
- The request strobe coincides with the pulse.

Only the bench scenarios can show the rest:
- The exact timing of the first period after reset, and of the default ratio after a second reset with no valid ratio offered.
- That arbitrary activity on the inputs in non-pulse cycles leaves every interval unchanged.
- That the directed extremes 4, 255 and the clamped values 0 to 3 produce the intended intervals.

// File: rtl/vcodiv_pkg.sv
package vcodiv_pkg;
  localparam int RATIO_W     = 8;
  localparam int MIN_RATIO   = 4;
  localparam int RESET_RATIO = 90;
endpackage

// File: rtl/vcodiv_ratio_sel.sv
// Picks the ratio for the next period: fresh (clamped) or held.
module vcodiv_ratio_sel #(
  parameter int W   = vcodiv_pkg::RATIO_W,
  parameter int MIN = vcodiv_pkg::MIN_RATIO,
  parameter int RST = vcodiv_pkg::RESET_RATIO
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] ratio_i,
  input  logic         valid_i,
  output logic [W-1:0] next_ratio_o
);
  logic [W-1:0] clamped;
  logic [W-1:0] held_q;

  generate
    if (MIN > 1) begin : g_clamp
      assign clamped = (ratio_i < W'(MIN)) ? W'(MIN) : ratio_i;
    end else begin : g_pass
      assign clamped = ratio_i;
    end
  endgenerate

  assign next_ratio_o = valid_i ? clamped : held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= W'(RST);
    else if (load_i) held_q <= next_ratio_o;
  end
endmodule

// File: rtl/vcodiv_counter.sv
// Down counter: loads N-1 at terminal count, so each period is N cycles.
module vcodiv_counter #(
  parameter int W   = vcodiv_pkg::RATIO_W,
  parameter int RST = vcodiv_pkg::RESET_RATIO
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] next_ratio_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;

  assign tc_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= W'(RST - 1);
    else if (tc_o) cnt_q <= next_ratio_i - W'(1);
    else           cnt_q <= cnt_q - W'(1);
  end
endmodule

// File: rtl/vco_divider.sv
module vco_divider #(
  parameter int RATIO_W     = vcodiv_pkg::RATIO_W,
  parameter int MIN_RATIO   = vcodiv_pkg::MIN_RATIO,
  parameter int RESET_RATIO = vcodiv_pkg::RESET_RATIO
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               ratio_valid_i,
  output logic               fb_pulse_o,
  output logic               ratio_req_o
);
  logic               tc;
  logic [RATIO_W-1:0] next_ratio;

  vcodiv_ratio_sel #(.W(RATIO_W), .MIN(MIN_RATIO), .RST(RESET_RATIO)) u_sel (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (tc),
    .ratio_i      (ratio_i),
    .valid_i      (ratio_valid_i),
    .next_ratio_o (next_ratio)
  );

  vcodiv_counter #(.W(RATIO_W), .RST(RESET_RATIO)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .next_ratio_i (next_ratio),
    .tc_o         (tc)
  );

  assign fb_pulse_o  = tc;
  assign ratio_req_o = tc;
endmodule

// File: rtl/vcodiv_chk.sv
module vcodiv_chk #(
  parameter int W   = 8,
  parameter int MIN = 4,
  parameter int RST = 90
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] ratio_i,
  input logic         ratio_valid_i,
  input logic         fb_pulse_o,
  input logic         ratio_req_o
);
  logic [W:0] ivl_q;
  logic [W:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_q <= (W+1)'(1);
      exp_q <= (W+1)'(RST);
    end else if (fb_pulse_o) begin
      ivl_q <= (W+1)'(1);
      if (ratio_valid_i)
        exp_q <= (ratio_i < W'(MIN)) ? (W+1)'(MIN) : {1'b0, ratio_i};
    end else begin
      ivl_q <= ivl_q + (W+1)'(1);
    end
  end

  // R3
  period_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |-> (ivl_q == exp_q));

  // R7
  no_missed_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ivl_q <= exp_q);

  // R4
  min_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |-> !$past(fb_pulse_o) && !$past(fb_pulse_o, 2) && !$past(fb_pulse_o, 3));

  // R2
  req_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_req_o == fb_pulse_o);
endmodule

bind vco_divider vcodiv_chk #(.W(RATIO_W), .MIN(MIN_RATIO), .RST(RESET_RATIO)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ratio_i       (ratio_i),
  .ratio_valid_i (ratio_valid_i),
  .fb_pulse_o    (fb_pulse_o),
  .ratio_req_o   (ratio_req_o)
);

// File: tb/tb_vco_divider.sv
`timescale 1ns/1ps
module tb_vco_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ratio = 8'd0;
  logic       vld = 1'b0;
  logic       pulse, req;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  vco_divider dut (
    .clk_i(clk), .rst_ni(rst_n), .ratio_i(ratio), .ratio_valid_i(vld),
    .fb_pulse_o(pulse), .ratio_req_o(req)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int next_exp(input int r, input bit v, input int prev);
    if (!v) return prev;
    return (r < 4) ? 4 : r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int cyc, last, expv, k, r;
    bit v;
    string tag;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(pulse == 1'b0, "R1 pulse in reset", int'(pulse), 0);
    check(req == 1'b0, "R1 req in reset", int'(req), 0);
    rst_n = 1'b1;
    cyc = 0; last = -1; expv = 90; tag = "R1"; k = 0;
    while (k < 300) begin
      @(negedge clk);
      cyc++;
      if (req != pulse) check(1'b0, "R2", int'(req), int'(pulse));
      if (pulse) begin
        check(cyc - last == expv, tag, cyc - last, expv);
        last = cyc;
        case (k)
          0: begin r = 4;   v = 1'b1; tag = "R3"; end
          1: begin r = 255; v = 1'b1; tag = "R7"; end
          2: begin r = 0;   v = 1'b1; tag = "R4"; end
          3: begin r = 3;   v = 1'b1; tag = "R4"; end
          4: begin r = 1;   v = 1'b1; tag = "R4"; end
          5: begin r = 2;   v = 1'b1; tag = "R4"; end
          6: begin r = 7;   v = 1'b0; tag = "R5"; end
          7: begin r = 200; v = 1'b1; tag = "R3"; end
          8: begin r = 9;   v = 1'b0; tag = "R5"; end
          9: begin r = 255; v = 1'b1; tag = "R7"; end
          default: begin
            r = int'($urandom % 256);
            v = ($urandom % 8) != 0;
            tag = !v ? "R5" : ((r < 4) ? "R4" : "R6");
          end
        endcase
        ratio = 8'(r);
        vld = v;
        expv = next_exp(r, v, expv);
        k++;
      end else begin
        // R6: activity outside the pulse cycle
        ratio = 8'($urandom);
        vld = 1'($urandom);
      end
    end
    // R5: default ratio after a fresh reset with no valid ratio offered
    @(negedge clk);
    rst_n = 1'b0;
    vld = 1'b0;
    @(negedge clk);
    check(pulse == 1'b0, "R1 pulse in second reset", int'(pulse), 0);
    rst_n = 1'b1;
    cyc = 0; last = -1; k = 0;
    while (k < 3) begin
      @(negedge clk);
      cyc++;
      ratio = 8'($urandom);
      if (pulse) begin
        check(cyc - last == 90, "R5 default ratio", cyc - last, 90);
        last = cyc;
        k++;
      end
    end
    finish_run();
  end
endmodule